// File: doc/BRIEF.md
# Blinded Modular Exponentiator

This block raises a base to an exponent modulo a small modulus. It uses a left-to-right binary ladder. The accumulator starts at one, and the exponent is scanned from its top bit down to bit 0. Each step first squares the accumulator modulo N. It then multiplies by the base modulo N when the current exponent bit is set. Every modular product comes from one serial multiplier that handles one multiplier bit per clock. It doubles, reduces, conditionally adds, and reduces again.

Two side-channel hardening options can be selected per operation. With exponent blinding, the ladder runs on d + k·phi instead of d. When phi is the group order of the modulus, this gives the same result while changing the bit pattern that is walked. With message blinding, the base is first multiplied by a caller-supplied r, so the block returns (m·r)^d mod N; the caller removes r^d afterwards. A third option, fixed-timing mode, performs the multiply on every bit and discards the product when the bit is 0. This makes the run time independent of the exponent.

The caller pulses `start` with the operands present for that cycle. `busy` stays high until `done` pulses for one cycle with `result` valid.

Top module: `modexp_blind`

## Requirements
- R1: With both blinding options off, `result` equals base^d mod N for any 8-bit base and exponent and any modulus N of at least 1. Because the accumulator starts at 1 mod N, d = 0 yields 1 when N > 1, and N = 1 always yields 0.
- R2: With `blind_en` = 1, the exponent used is d + k·phi, computed as a full-width sum. If N is prime and phi = N−1, the result for any base not divisible by N equals the unblinded result.
- R3: With `mblind_en` = 1, the base used is (base·r) mod N, so `result` = (base·r)^d mod N.
- R4: With `fixed_time` = 1, the number of cycles from `start` to `done` does not depend on the exponent or the blinding value.
- R5: With `fixed_time` = 0, the multiply is skipped on exponent bits that are 0, so an exponent with more 1 bits takes strictly more cycles.
- R6: `done` is high for exactly one cycle per operation and is never high together with `busy`. `busy` is high from the cycle after an accepted `start` until `done`.
- R7: A `start` pulse while `busy` is high is ignored. The running operation finishes with its original operands, and no extra operation follows.
- R8: After reset, `busy`, `done` and `result` are all 0.
- R9: Every reported `result` is below N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (sampled only while idle) |
| base | input | W | Base m |
| expo | input | W | Exponent d |
| modulus | input | W | Modulus N, at least 1 |
| blind_en | input | 1 | Use d + k·phi as the exponent |
| blind_k | input | KW | Blinding multiplier k |
| phi | input | W | Group order supplied by the caller |
| mblind_en | input | 1 | Multiply the base by r before the ladder |
| mblind_r | input | W | Message blinding factor r |
| fixed_time | input | 1 | Multiply on every exponent bit |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse, result valid |
| result | output | W | Exponentiation result |

## Verification
The bench goes after several corner cases. Moduli of 1 and 2 stress the initial accumulator value and the reduction. A zero exponent checks whether the ladder starts at 1 rather than at the base. Bases at or above N check whether the base is reduced before use. A blinded exponent with a nonzero k and an arbitrary phi shows whether the high bits of the widened exponent are actually walked; a truncated sum would give a wrong power there. Latency is measured across exponents in both timing modes. A design that gated the dummy multiply would show exponent-dependent timing in fixed mode, and one that always multiplied would show flat timing in variable mode. A start pulse fired mid-run with different operands would reveal a design that relatches inputs or queues a second operation.

// File: rtl/modexp_pkg.sv
package modexp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BASE,
    ST_MSG,
    ST_SQR,
    ST_MUL
  } mx_state_e;

  // One interleaved multiply step: acc = (2*acc + bit*a) mod n, with acc, a < n.
  function automatic logic [31:0] mm_step(input logic [31:0] acc,
                                          input logic [31:0] a,
                                          input logic        bitv,
                                          input logic [31:0] n);
    logic [32:0] t;
    t = {acc, 1'b0};
    if (t >= {1'b0, n}) t = t - {1'b0, n};
    if (bitv) begin
      t = t + {1'b0, a};
      if (t >= {1'b0, n}) t = t - {1'b0, n};
    end
    return t[31:0];
  endfunction

  // Effective exponent: d, or d + k*phi when blinding is on.
  function automatic logic [63:0] blind_exp(input logic [31:0] d,
                                            input logic [31:0] k,
                                            input logic [31:0] phi,
                                            input logic        en);
    logic [63:0] prod;
    prod = 64'(k) * 64'(phi);
    return en ? (64'(d) + prod) : 64'(d);
  endfunction

endpackage

// File: rtl/modmul_serial.sv
module modmul_serial
  import modexp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] n,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] p
);
  localparam int IW = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]  a_q, b_q, n_q, acc_q;
  logic [IW-1:0] idx_q;
  logic          busy_q, done_q;
  logic          last_bit;

  assign last_bit = (idx_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= '0;
      b_q    <= '0;
      n_q    <= '0;
      acc_q  <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        acc_q <= W'(mm_step(32'(acc_q), 32'(a_q), b_q[idx_q], 32'(n_q)));
        if (last_bit) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx_q <= idx_q - 1'b1;
        end
      end else if (start) begin
        a_q    <= a;
        b_q    <= b;
        n_q    <= n;
        acc_q  <= '0;
        idx_q  <= IW'(W - 1);
        busy_q <= 1'b1;
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign p    = acc_q;

  // R9: each partial product handed to the ladder is already reduced.
  p_mm_reduced_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (acc_q < n_q));

  p_mm_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

endmodule

// File: rtl/expo_blinder.sv
module expo_blinder
  import modexp_pkg::*;
#(
  parameter int W  = 8,
  parameter int KW = 3,
  parameter int EW = W + KW + 1
) (
  input  logic          en,
  input  logic [W-1:0]  d,
  input  logic [KW-1:0] k,
  input  logic [W-1:0]  phi,
  output logic [EW-1:0] eff
);
  assign eff = EW'(blind_exp(32'(d), 32'(k), 32'(phi), en));
endmodule

// File: rtl/modexp_blind.sv
module modexp_blind
  import modexp_pkg::*;
#(
  parameter int W  = 8,
  parameter int KW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [W-1:0]  base,
  input  logic [W-1:0]  expo,
  input  logic [W-1:0]  modulus,
  input  logic          blind_en,
  input  logic [KW-1:0] blind_k,
  input  logic [W-1:0]  phi,
  input  logic          mblind_en,
  input  logic [W-1:0]  mblind_r,
  input  logic          fixed_time,
  output logic          busy,
  output logic          done,
  output logic [W-1:0]  result
);
  localparam int EW  = W + KW + 1;
  localparam int EIW = $clog2(EW);

  mx_state_e     st;
  logic [W-1:0]  n_q, r_q, mb_q, acc_q, res_q, op_a, op_b;
  logic [EW-1:0] eexp_q, eexp_in;
  logic [EIW-1:0] bit_q;
  logic          msg_q, ct_q, mm_go, busy_q, done_q;

  logic          mm_busy, mm_done;
  logic [W-1:0]  mm_p;

  expo_blinder #(.W(W), .KW(KW), .EW(EW)) u_blind (
    .en(blind_en), .d(expo), .k(blind_k), .phi(phi), .eff(eexp_in)
  );

  modmul_serial #(.W(W)) u_mul (
    .clk(clk), .rst_n(rst_n), .start(mm_go), .a(op_a), .b(op_b), .n(n_q),
    .busy(mm_busy), .done(mm_done), .p(mm_p)
  );

  // Named internal events for the assertions.
  logic         exp_bit, last_bit, sq_fin, mul_fin, take_mul;
  logic [W-1:0] kept;
  assign exp_bit  = eexp_q[bit_q];
  assign last_bit = (bit_q == '0);
  assign sq_fin   = (st == ST_SQR) && mm_done;
  assign mul_fin  = (st == ST_MUL) && mm_done;
  assign take_mul = exp_bit || ct_q;
  assign kept     = exp_bit ? mm_p : acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      n_q    <= '0;
      r_q    <= '0;
      mb_q   <= '0;
      acc_q  <= '0;
      res_q  <= '0;
      op_a   <= '0;
      op_b   <= '0;
      eexp_q <= '0;
      bit_q  <= '0;
      msg_q  <= 1'b0;
      ct_q   <= 1'b0;
      mm_go  <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      mm_go  <= 1'b0;
      done_q <= 1'b0;
      unique case (st)
        ST_IDLE: if (start) begin
          n_q    <= modulus;
          r_q    <= mblind_r;
          msg_q  <= mblind_en;
          ct_q   <= fixed_time;
          eexp_q <= eexp_in;
          bit_q  <= EIW'(EW - 1);
          acc_q  <= (modulus == W'(1)) ? '0 : W'(1);
          op_a   <= W'(1);          // base mod N computed as 1 * base
          op_b   <= base;
          mm_go  <= 1'b1;
          busy_q <= 1'b1;
          st     <= ST_BASE;
        end
        ST_BASE: if (mm_done) begin
          mb_q  <= mm_p;
          mm_go <= 1'b1;
          if (msg_q) begin
            op_a <= mm_p;
            op_b <= r_q;
            st   <= ST_MSG;
          end else begin
            op_a <= acc_q;
            op_b <= acc_q;
            st   <= ST_SQR;
          end
        end
        ST_MSG: if (mm_done) begin
          mb_q  <= mm_p;
          op_a  <= acc_q;
          op_b  <= acc_q;
          mm_go <= 1'b1;
          st    <= ST_SQR;
        end
        ST_SQR: if (mm_done) begin
          acc_q <= mm_p;
          if (take_mul) begin
            op_a  <= mm_p;
            op_b  <= mb_q;
            mm_go <= 1'b1;
            st    <= ST_MUL;
          end else if (last_bit) begin
            res_q  <= mm_p;
            done_q <= 1'b1;
            busy_q <= 1'b0;
            st     <= ST_IDLE;
          end else begin
            bit_q <= bit_q - 1'b1;
            op_a  <= mm_p;
            op_b  <= mm_p;
            mm_go <= 1'b1;
          end
        end
        ST_MUL: if (mm_done) begin
          acc_q <= kept;
          if (last_bit) begin
            res_q  <= kept;
            done_q <= 1'b1;
            busy_q <= 1'b0;
            st     <= ST_IDLE;
          end else begin
            bit_q <= bit_q - 1'b1;
            op_a  <= kept;
            op_b  <= kept;
            mm_go <= 1'b1;
            st    <= ST_SQR;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy   = busy_q;
  assign done   = done_q;
  assign result = res_q;

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  p_done_not_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);

  p_hold_operands_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> ($stable(eexp_q) && $stable(n_q) && $stable(r_q)));

  p_result_reduced_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (res_q < n_q));

  p_fixed_mul_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_fin && ct_q) |=> (st == ST_MUL));

  p_skip_mul_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_fin && !ct_q && !exp_bit) |=> (st != ST_MUL));

  p_mul_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    mm_go |-> !mm_busy);

endmodule

// File: tb/modexp_blind_tb.sv
module modexp_blind_tb;
  localparam int W  = 8;
  localparam int KW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] base = '0, expo = '0, modulus = 8'd1, phi = '0, mblind_r = '0;
  logic [KW-1:0] blind_k = '0;
  logic blind_en = 1'b0, mblind_en = 1'b0, fixed_time = 1'b0;
  logic busy, done;
  logic [W-1:0] result;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  modexp_blind #(.W(W), .KW(KW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .base(base), .expo(expo),
    .modulus(modulus), .blind_en(blind_en), .blind_k(blind_k), .phi(phi),
    .mblind_en(mblind_en), .mblind_r(mblind_r), .fixed_time(fixed_time),
    .busy(busy), .done(done), .result(result)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: expected completion, actual hang after %0d cycles", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // Right-to-left reference, different ordering from the design.
  function automatic longint unsigned pmod(longint unsigned m, longint unsigned e,
                                           longint unsigned n);
    longint unsigned r, b;
    r = 1 % n;
    b = m % n;
    while (e != 0) begin
      if (e[0]) r = (r * b) % n;
      b = (b * b) % n;
      e = e >> 1;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [7:0] m, d, n, r, ph, input logic [2:0] k,
                        input logic be, me, ct, output logic [7:0] res, output int lat);
    @(negedge clk);
    base = m; expo = d; modulus = n; mblind_r = r; phi = ph; blind_k = k;
    blind_en = be; mblind_en = me; fixed_time = ct; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 6000) begin
      @(negedge clk);
      lat++;
    end
    res = result;
  endtask

  function automatic longint unsigned ref_of(logic [7:0] m, d, n, r, ph, logic [2:0] k,
                                             logic be, me);
    longint unsigned e, mb;
    e  = be ? (longint'(d) + longint'(k) * longint'(ph)) : longint'(d);
    mb = me ? (longint'(m) * longint'(r)) % longint'(n) : longint'(m);
    return pmod(mb, e, longint'(n));
  endfunction

  initial begin
    logic [7:0] res, res2;
    int lat, lat0, lat1, lat2;
    longint unsigned exp_v;

    repeat (3) @(negedge clk);
    // R8: reset state
    check(busy == 1'b0, "R8 busy", busy, 0);
    check(done == 1'b0, "R8 done", done, 0);
    check(result == '0, "R8 result", result, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: directed corner cases
    run_op(8'd5, 8'd0, 8'd13, 8'd0, 8'd0, 3'd0, 0, 0, 0, res, lat);
    check(res == 8'd1, "R1 d=0", res, 1);
    run_op(8'd200, 8'd77, 8'd1, 8'd0, 8'd0, 3'd0, 0, 0, 0, res, lat);
    check(res == 8'd0, "R1 N=1", res, 0);
    run_op(8'd255, 8'd255, 8'd2, 8'd0, 8'd0, 3'd0, 0, 0, 1, res, lat);
    check(res == 8'd1, "R1 N=2", res, 1);
    run_op(8'd250, 8'd3, 8'd7, 8'd0, 8'd0, 3'd0, 0, 0, 0, res, lat);
    exp_v = pmod(250, 3, 7);
    check(res == 8'(exp_v), "R1 base>=N", res, exp_v);

    // R6: handshake timing
    @(negedge clk);
    base = 8'd3; expo = 8'd9; modulus = 8'd11; blind_en = 0; mblind_en = 0; fixed_time = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R6 busy after start", busy, 1);
    while (!done) @(negedge clk);
    check(busy == 1'b0, "R6 busy low with done", busy, 0);
    exp_v = pmod(3, 9, 11);
    check(result == 8'(exp_v), "R1 handshake run", result, exp_v);
    @(negedge clk);
    check(done == 1'b0, "R6 done one cycle", done, 0);

    // R7: start while busy is ignored
    @(negedge clk);
    base = 8'd7; expo = 8'd200; modulus = 8'd97; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    base = 8'd2; expo = 8'd5; modulus = 8'd31; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    exp_v = pmod(7, 200, 97);
    check(result == 8'(exp_v), "R7 original operands", result, exp_v);
    lat = 0;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (done) lat++;
    end
    check(lat == 0, "R7 no queued run", lat, 0);

    // R2: blinding with phi = N-1 on prime N matches unblinded
    for (int i = 0; i < 40; i++) begin
      logic [7:0] m, d;
      logic [2:0] k;
      m = 8'($urandom_range(1, 250));
      d = 8'($urandom);
      k = 3'($urandom_range(1, 7));
      run_op(m, d, 8'd251, 8'd0, 8'd250, k, 1, 0, 0, res, lat);
      exp_v = pmod(m, d, 251);
      check(res == 8'(exp_v), "R2 blinded equals plain", res, exp_v);
    end
    // R2: arbitrary phi, full-width effective exponent walked
    run_op(8'd3, 8'd255, 8'd253, 8'd0, 8'd255, 3'd7, 1, 0, 0, res, lat);
    exp_v = pmod(3, 255 + 7 * 255, 253);
    check(res == 8'(exp_v), "R2 wide exponent", res, exp_v);

    // R3: message blinding
    run_op(8'd10, 8'd17, 8'd29, 8'd200, 8'd0, 3'd0, 0, 1, 0, res, lat);
    exp_v = pmod((10 * 200) % 29, 17, 29);
    check(res == 8'(exp_v), "R3 message blind", res, exp_v);

    // R4: fixed timing independent of exponent
    run_op(8'd9, 8'd0, 8'd101, 8'd0, 8'd0, 3'd0, 0, 0, 1, res, lat0);
    run_op(8'd9, 8'd255, 8'd101, 8'd0, 8'd0, 3'd0, 0, 0, 1, res, lat1);
    run_op(8'd9, 8'd77, 8'd101, 8'd0, 8'd77, 3'd5, 1, 0, 1, res2, lat2);
    check(lat0 == lat1, "R4 latency d=0 vs d=255", lat0, lat1);
    check(lat0 == lat2, "R4 latency blinded", lat2, lat0);
    exp_v = pmod(9, 255, 101);
    check(res == 8'(exp_v), "R4 fixed result", res, exp_v);

    // R5: variable timing grows with 1 bits
    run_op(8'd9, 8'h00, 8'd101, 8'd0, 8'd0, 3'd0, 0, 0, 0, res, lat0);
    run_op(8'd9, 8'h0F, 8'd101, 8'd0, 8'd0, 3'd0, 0, 0, 0, res, lat1);
    run_op(8'd9, 8'hFF, 8'd101, 8'd0, 8'd0, 3'd0, 0, 0, 0, res, lat2);
    check(lat1 > lat0, "R5 more ones slower (0F vs 00)", lat1, lat0);
    check(lat2 > lat1, "R5 more ones slower (FF vs 0F)", lat2, lat1);

    // R1 R2 R3 R9: random sweep over all options
    for (int i = 0; i < 250; i++) begin
      logic [7:0] m, d, n, r, ph;
      logic [2:0] k;
      logic be, me, ct;
      m = 8'($urandom); d = 8'($urandom); n = 8'($urandom_range(1, 255));
      r = 8'($urandom); ph = 8'($urandom); k = 3'($urandom);
      be = 1'($urandom); me = 1'($urandom); ct = 1'($urandom);
      run_op(m, d, n, r, ph, k, be, me, ct, res, lat);
      exp_v = ref_of(m, d, n, r, ph, k, be, me);
      check(res == 8'(exp_v), "R1 random sweep", res, exp_v);
      check(res < n, "R9 reduced", res, n);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule